// File: doc/BRIEF.md
# Edge-to-Pulse Channel Encoder with Refresh

This block is the transmit side of a single-bit channel that carries a logic level across a barrier as short strobes rather than as a level. The input is first synchronised into the clock domain and then glitch-filtered. Each accepted low-to-high change is sent as a one-clock `set_o` strobe. Each accepted high-to-low change is sent as a one-clock `reset_o` strobe. The receiving side holds a bistable latch that these strobes set or clear.

A far-side latch can lose its state, so the encoder repeats the current level while the input is quiet. After an idle interval with no accepted change, it emits a strobe that matches the present level. It then repeats that strobe at a fixed refresh period until the next accepted change. Every interval is a count of clock cycles and is set by a parameter. One refresh is also sent straight after reset, so the far side learns the level without waiting.

Top module: `edge_pulse_enc`

## Requirements
- R1: A new level on `din_i` that holds for at least `MIN_PW_CYC` cycles produces its strobe on rising edge number `SYNC_STAGES + MIN_PW_CYC`. Edge number 1 is the first rising edge that samples the new value.
- R2: An accepted change to 1 gives `set_o` high for exactly one cycle, and an accepted change to 0 gives `reset_o` high for exactly one cycle.
- R3: A level on `din_i` that lasts fewer than `MIN_PW_CYC` cycles before returning produces no strobe and does not disturb the refresh schedule.
- R4: The first refresh after an accepted change is issued `IDLE_CYC` cycles after that change's strobe. A refresh is `set_o` when the filtered level is 1 and `reset_o` when it is 0.
- R5: While no change is accepted, refreshes repeat every `REFRESH_CYC` cycles after the previous refresh.
- R6: When an accepted change falls in the cycle where a refresh is due, only the change strobe is issued, and the next refresh follows `IDLE_CYC` cycles later.
- R7: `set_o` and `reset_o` are never high in the same cycle.
- R8: While `rst_ni` is low, both strobes are low and the filtered level is 1.
- R9: On the first rising edge after `rst_ni` goes high, one refresh of the filtered level is issued. Because the level is 1 at that point, this refresh is a `set_o`. Periodic refreshes then follow every `REFRESH_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Asynchronous logic input to be carried |
| set_o | output | 1 | One-cycle strobe: far-side latch to 1 |
| reset_o | output | 1 | One-cycle strobe: far-side latch to 0 |

## Verification
An accepted input change and a due refresh can fall on the same clock edge. The bench provokes this on purpose: it computes when the next refresh is due and times an input change so that its filter acceptance lands on exactly that edge. The bench passes the case only if a single strobe of the new level appears in that cycle, with no refresh of the old level. The following refresh must then arrive `IDLE_CYC` cycles later rather than `REFRESH_CYC` cycles later. A scoreboard built from the requirements checks every strobe by cycle and polarity, so a missing, extra, late or doubled strobe is reported.

// File: rtl/edge_pulse_enc_pkg.sv
package edge_pulse_enc_pkg;
  typedef enum logic [1:0] {
    STB_NONE = 2'd0,
    STB_SET  = 2'd1,
    STB_RST  = 2'd2
  } strobe_e;

  function automatic strobe_e level_strobe(input logic lvl);
    return lvl ? STB_SET : STB_RST;
  endfunction
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/enc_glitch_filt.sv
module enc_glitch_filt #(
  parameter int MIN_PW_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_s_i,
  output logic lvl_o,
  output logic chg_o
);
  localparam int CW = $clog2(MIN_PW_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          diff;

  assign diff  = din_s_i != lvl_q;
  // chg_o: this edge accepts the new level
  assign chg_o = diff && (cnt_q == CW'(MIN_PW_CYC - 1));
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (!diff) begin
      cnt_q <= '0;
    end else if (chg_o) begin
      cnt_q <= '0;
      lvl_q <= din_s_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_LVL_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(din_s_i) == lvl_q); // R3
endmodule

// File: rtl/enc_refresh_tmr.sv
module enc_refresh_tmr #(
  parameter int IDLE_CYC    = 200,
  parameter int REFRESH_CYC = 340
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  output logic fire_o
);
  localparam int MAXC = (IDLE_CYC > REFRESH_CYC) ? IDLE_CYC : REFRESH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          boot_q;
  logic          first_q;
  logic          due;

  assign due    = first_q ? (cnt_q == CW'(IDLE_CYC - 1)) : (cnt_q == CW'(REFRESH_CYC - 1));
  assign fire_o = !chg_i && (boot_q || due);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      boot_q  <= 1'b1;
      first_q <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if (chg_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (fire_o) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R5
endmodule

// File: rtl/edge_pulse_enc.sv
module edge_pulse_enc
  import edge_pulse_enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW_CYC  = 8,
  parameter int IDLE_CYC    = 200,
  parameter int REFRESH_CYC = 340
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic set_o,
  output logic reset_o
);
  logic    din_s;
  logic    lvl;
  logic    chg;
  logic    fire;
  strobe_e stb;

  enc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (din_s)
  );

  enc_glitch_filt #(.MIN_PW_CYC(MIN_PW_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_s_i(din_s),
    .lvl_o  (lvl),
    .chg_o  (chg)
  );

  enc_refresh_tmr #(.IDLE_CYC(IDLE_CYC), .REFRESH_CYC(REFRESH_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .chg_i (chg),
    .fire_o(fire)
  );

  // change wins over refresh; refresh carries current level
  always_comb begin
    if (chg)       stb = level_strobe(~lvl);
    else if (fire) stb = level_strobe(lvl);
    else           stb = STB_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o   <= 1'b0;
      reset_o <= 1'b0;
    end else begin
      set_o   <= (stb == STB_SET);
      reset_o <= (stb == STB_RST);
    end
  end

  AST_NOT_BOTH:      assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_o && reset_o)); // R7
  AST_RISE_GIVES_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl) |-> set_o); // R2
  AST_FALL_GIVES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl) |-> reset_o); // R2
  AST_SET_MATCHES:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> lvl); // R4
  AST_RST_MATCHES:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> !lvl); // R4
  AST_SET_ONE_CYC:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o); // R2
endmodule

// File: tb/edge_pulse_enc_tb.sv
module edge_pulse_enc_tb;
  localparam int S   = 2;
  localparam int MIN = 4;
  localparam int IDL = 20;
  localparam int REF = 12;

  typedef struct {
    int    cyc;
    bit    lvl;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic set_w, rst_w;

  int    cyc;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  exp_t  q[$];
  bit    lvl;
  int    next_ref;
  string ref_tag;

  always #2.5 clk = ~clk;

  edge_pulse_enc #(.SYNC_STAGES(S), .MIN_PW_CYC(MIN), .IDLE_CYC(IDL), .REFRESH_CYC(REF)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .din_i  (din),
    .set_o  (set_w),
    .reset_o(rst_w)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= -1;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        exp_t m;
        m = q.pop_front();
        chk(1'b0, m.tag, -1, m.cyc);
      end
      if (set_w && rst_w) chk(1'b0, "R7", 2, 1);
      if (set_w || rst_w) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.cyc == cyc, e.tag, cyc, e.cyc);
          chk(e.lvl == set_w, e.tag, int'(set_w), int'(e.lvl));
        end
      end
    end
  end

  task automatic push(input int c, input bit v, input string tag);
    exp_t e;
    e.cyc = c; e.lvl = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic flush(input int c);
    while (next_ref <= c) begin
      push(next_ref, lvl, ref_tag);
      next_ref += (ref_tag == "R4" || ref_tag == "R9") ? REF : REF;
      ref_tag = "R5";
    end
  endtask

  task automatic wait_to(input int c);
    flush(c);
    while (cyc < c) @(negedge clk);
  endtask

  // accepted change: held until the strobe appears
  task automatic set_din(input bit v, input string tag);
    int a;
    a = cyc + S + MIN;
    din = v;
    flush(a - 1);
    push(a, v, tag);
    lvl = v;
    next_ref = a + IDL;
    ref_tag = "R4";
    wait_to(a);
  endtask

  task automatic glitch(input bit v, input int w);
    flush(cyc + w + S + MIN + 2);
    din = v;
    repeat (w) @(negedge clk);
    din = ~v;
  endtask

  task automatic start_after_reset(input bit din_at_release);
    q.delete();
    lvl = 1'b1;
    next_ref = 0;
    ref_tag = "R9";
    @(negedge clk);
    rst_n = 1'b1;
    if (!din_at_release) begin
      flush(-1 + S + MIN - 1);
      push(-1 + S + MIN, 1'b0, "R1");
      lvl = 1'b0;
      next_ref = -1 + S + MIN + IDL;
      ref_tag = "R4";
    end
  endtask

  initial begin
    #100000;
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(!set_w && !rst_w, "R8", int'(set_w | rst_w), 0);
    end
    start_after_reset(1'b1);
    wait_to(30);
    set_din(1'b0, "R2");                 // falling -> reset strobe
    wait_to(cyc + IDL + 2 * REF + 1);
    glitch(1'b1, MIN - 1);               // R3: too short
    wait_to(cyc + 3 * REF);
    glitch(1'b1, 1);                     // R3: single cycle
    wait_to(cyc + REF + 3);
    set_din(1'b1, "R1");                 // rising -> set strobe
    set_din(1'b0, "R2");                 // back-to-back minimal width
    wait_to(cyc + IDL + REF + 2);
    // R6: acceptance lands on a periodic refresh edge
    wait_to(next_ref - S - MIN);
    set_din(1'b1, "R6");
    // R6: acceptance lands on the first refresh after a change
    wait_to(next_ref - S - MIN);
    set_din(1'b0, "R6");
    wait_to(cyc + IDL + 2 * REF + 1);
    // second reset with input held low
    @(negedge clk);
    din = 1'b0;
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!set_w && !rst_w, "R8", int'(set_w | rst_w), 0);
    end
    start_after_reset(1'b0);
    wait_to(S + MIN + IDL + 3 * REF);
    chk(q.size() == 0, "R5", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule